// File: doc/BRIEF.md
# Half-Duplex Handshake Link Controller

This block is the host end of a byte-serial, half-duplex link to a peripheral microcontroller. Three sideband lines carry the handshake. The host drives `tip_n_o`, which goes low while a transaction is in progress, and `ack_o`, which toggles once per byte. The peripheral drives `req_n_i`, an active-low request. The bit-level shifting is done outside the block by a shift register. The controller steers that register through a direction select, a parallel load port and a byte-complete strobe.

The controller sends one frame at a time. It reads the frame bytes from an external transmit buffer through an addressed read port. It writes every received byte into an external receive buffer and reports each finished frame with its type byte and payload length. When the peripheral requests the link while the host is writing, the peripheral wins. The host abandons its frame, receives the incoming one, and then retries its own frame from the first byte. After reset the block runs a fixed four-step wake-up handshake on the sideband lines. It ignores the shift register until that handshake has finished.

All waits are counted in clock cycles. The parameter `CYC_PER_US` gives the number of cycles per microsecond. The short wait is `SHORT_US` microseconds and the long wait is `LONG_US` microseconds. The receive write port and the frame report are plain strobes with no back-pressure: the buffers behind them must accept a byte on every cycle in which `rx_wr_en_o` or `frame_done_o` is high. The transmit read port is combinational: `tx_rd_data_i` must show the byte at `tx_rd_addr_o` in the same cycle.

Top module: `hdx_link_ctrl`

## Requirements
- R1: Whenever the controller is idle, `tip_n_o` and `ack_o` are both 1 and `sr_dir_out_o` is 0 (shift direction in).
- R2: After reset release, the handshake runs in four steps spaced S = `SHORT_US`*`CYC_PER_US` cycles apart:
  - on clock edge S, `tip_n_o` goes 0;
  - on edge 2S, `ack_o` goes 0;
  - on edge 3S, `tip_n_o` goes 1;
  - on edge 4S, `ack_o` goes 1 and the controller becomes idle.
  During the handshake, `sr_done_i` has no effect and `busy_o` is 1.
- R3: A `tx_start_i` pulse while `busy_o` is 0 latches `tx_len_i` (1 to 256) and makes the transmit pending. A transmission starts from idle only while `req_n_i` is 1. On the starting edge:
  - `sr_dir_out_o` becomes 1;
  - `sr_load_o` pulses with the byte at address 0;
  - `ack_o` is forced to 1;
  - `tip_n_o` goes 0.
- R4: While transmitting, each `sr_done_i` with `req_n_i` at 1 counts one byte as sent. If the count now equals the length, the lines return to idle and the pending transmit clears. Otherwise `sr_load_o` pulses with the byte at address count and `ack_o` toggles.
- R5: A `sr_done_i` with `req_n_i` at 0 during a transmission is a collision. On that edge:
  - `sr_dir_out_o` becomes 0;
  - `ack_o` becomes 1;
  - `tip_n_o` stays 0;
  - the controller enters receive with the transmit still pending.
- R6: A `sr_done_i` in idle with `req_n_i` at 1 is spurious. With no transmit pending it changes no output. With a transmit pending, the transmission restarts from byte 0 S cycles later, provided `req_n_i` is then 1.
- R7: A `sr_done_i` in idle with `req_n_i` at 0 opens an incoming frame. `tip_n_o` goes 0 and direction stays in. The byte shifted with that strobe is an attention byte and is discarded.
- R8: In receive, each `sr_done_i` writes `sr_rdata_i` to the receive port at addresses 0, 1, 2, and so on. If `req_n_i` is 0 the byte is not the last, and `ack_o` toggles. If `req_n_i` is 1 the byte is the last.
- R9: On the last byte, `frame_done_o` pulses and the lines return to idle. `frame_type_o` is the first stored byte. `frame_len_o` is the number of stored bytes minus one.
- R10: When the 256th byte of a frame is stored, the frame ends whatever the level of `req_n_i`. The report has `frame_ovf_o` at 1 and `frame_len_o` equal to 254.
- R11: If a transmit is pending when a frame ends, the controller waits L = `LONG_US`*`CYC_PER_US` cycles. If `req_n_i` is then 1, the transmission starts from byte 0. If `req_n_i` is 0, the controller returns to idle with the transmit still pending.
- R12: `busy_o` is 1 whenever the controller is not idle or a transmit is pending. A `tx_start_i` pulse while `busy_o` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start_i | input | 1 | Request to send one frame |
| tx_len_i | input | 9 | Frame length in bytes, 1 to 256 |
| tx_rd_addr_o | output | 8 | Transmit buffer read address |
| tx_rd_data_i | input | 8 | Transmit buffer byte at `tx_rd_addr_o` |
| req_n_i | input | 1 | Peripheral request, active low |
| tip_n_o | output | 1 | Transaction in progress, active low |
| ack_o | output | 1 | Byte acknowledge, toggled per byte |
| sr_dir_out_o | output | 1 | Shift direction, 1 = host to peripheral |
| sr_load_o | output | 1 | Load strobe for the shift register |
| sr_wdata_o | output | 8 | Byte to load |
| sr_rdata_i | input | 8 | Byte read from the shift register |
| sr_done_i | input | 1 | Byte-complete strobe |
| rx_wr_en_o | output | 1 | Receive buffer write strobe |
| rx_wr_addr_o | output | 8 | Receive buffer write address |
| rx_wr_data_o | output | 8 | Receive buffer write data |
| frame_done_o | output | 1 | Received frame finished |
| frame_type_o | output | 8 | Type byte of the finished frame |
| frame_len_o | output | 9 | Payload length of the finished frame |
| frame_ovf_o | output | 1 | Finished frame hit the length limit |
| busy_o | output | 1 | Controller busy or transmit pending |

## Verification
Every registered output changes on the clock edge that samples its cause, so its result is due one edge after the stimulus: line changes, load pulses, receive writes and frame reports. Waits are the exception and land exactly S or L edges after the edge that armed them. The handshake steps are due S, 2S, 3S and 4S edges after reset release. `busy_o` follows the state with no extra register. The bench runs a behavioural model on the same edges with a countdown integer for each wait, and compares every output on the falling edge. Data fields are compared only in the cycles in which their strobe is expected.

// File: rtl/hdx_link_pkg.sv
package hdx_link_pkg;

  // Controller states. The four HS_* steps form the power-up handshake.
  typedef enum logic [2:0] {
    ST_HS_A,
    ST_HS_B,
    ST_HS_C,
    ST_HS_D,
    ST_IDLE,
    ST_TX,
    ST_RX,
    ST_HOLD
  } link_st_e;

endpackage

// File: rtl/hdx_delay_timer.sv
module hdx_delay_timer #(
  parameter int          TW       = 16,
  parameter int unsigned RST_LOAD = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [TW-1:0] load_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;

  // A load of N-1 makes expired_o true before edge N after the arming edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= TW'(RST_LOAD);
    else if (arm_i)          cnt_q <= load_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !arm_i) |=> expired_o);  // R11

endmodule

// File: rtl/hdx_rx_capture.sv
module hdx_rx_capture #(
  parameter int DW        = 8,
  parameter int MAX_FRAME = 256,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1),
  parameter int AW        = $clog2(MAX_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             begin_i,
  input  logic             byte_i,
  input  logic             last_req_i,
  input  logic [DW-1:0]    data_i,
  output logic             full_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             done_o,
  output logic [DW-1:0]    type_o,
  output logic [CNT_W-1:0] len_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] LEN_OVF = CNT_W'(MAX_FRAME - 2);

  // Count starts at 1 after the attention byte and saturates at MAX_FRAME.
  logic [CNT_W-1:0] rcnt_q;
  logic [CNT_W-1:0] rcnt_dec;
  logic [DW-1:0]    type_q;
  logic             first_byte;

  assign full_o     = (rcnt_q == CNT_MAX);
  assign rcnt_dec   = rcnt_q - 1'b1;
  assign first_byte = (rcnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q    <= '0;
      type_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      type_o    <= '0;
      len_o     <= '0;
      ovf_o     <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
      if (begin_i) begin
        rcnt_q <= CNT_W'(1);
      end else if (byte_i) begin
        wr_en_o   <= 1'b1;
        wr_addr_o <= rcnt_dec[AW-1:0];
        wr_data_o <= data_i;
        if (first_byte) type_q <= data_i;
        if (!full_o)    rcnt_q <= rcnt_q + 1'b1;
        if (last_req_i || full_o) begin
          done_o <= 1'b1;
          type_o <= first_byte ? data_i : type_q;
          len_o  <= full_o ? LEN_OVF : rcnt_dec;
          ovf_o  <= full_o;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt_q <= CNT_MAX);  // R10
  AST_OVF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovf_o) |-> (len_o == LEN_OVF));  // R10
  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> wr_en_o);  // R9

endmodule

// File: rtl/hdx_link_ctrl.sv
module hdx_link_ctrl #(
  parameter int DW         = 8,
  parameter int MAX_FRAME  = 256,
  parameter int CYC_PER_US = 100,
  parameter int SHORT_US   = 150,
  parameter int LONG_US    = 1500,
  parameter int CNT_W      = $clog2(MAX_FRAME + 1),
  parameter int AW         = $clog2(MAX_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_start_i,
  input  logic [CNT_W-1:0] tx_len_i,
  output logic [AW-1:0]    tx_rd_addr_o,
  input  logic [DW-1:0]    tx_rd_data_i,
  input  logic             req_n_i,
  output logic             tip_n_o,
  output logic             ack_o,
  output logic             sr_dir_out_o,
  output logic             sr_load_o,
  output logic [DW-1:0]    sr_wdata_o,
  input  logic [DW-1:0]    sr_rdata_i,
  input  logic             sr_done_i,
  output logic             rx_wr_en_o,
  output logic [AW-1:0]    rx_wr_addr_o,
  output logic [DW-1:0]    rx_wr_data_o,
  output logic             frame_done_o,
  output logic [DW-1:0]    frame_type_o,
  output logic [CNT_W-1:0] frame_len_o,
  output logic             frame_ovf_o,
  output logic             busy_o
);
  import hdx_link_pkg::*;

  localparam int unsigned SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int unsigned LONG_CYC  = LONG_US * CYC_PER_US;
  localparam int          TW        = $clog2(LONG_CYC + 1);
  localparam logic [TW-1:0] SHORT_LOAD = TW'(SHORT_CYC - 1);
  localparam logic [TW-1:0] LONG_LOAD  = TW'(LONG_CYC - 1);

  link_st_e         st_q, st_d;
  logic             tip_q, tip_d, ack_q, ack_d, dir_q, dir_d;
  logic             load_q, load_d;
  logic [DW-1:0]    wdat_q, wdat_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] scnt_q, scnt_d, len_q, len_d, scnt_inc;
  logic             tmr_arm, tmr_exp;
  logic [TW-1:0]    tmr_load;
  logic             rx_begin, rx_byte, rx_full;
  logic             accept, start_tx, in_hs;

  hdx_delay_timer #(.TW(TW), .RST_LOAD(SHORT_CYC - 1)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (tmr_arm),
    .load_i    (tmr_load),
    .expired_o (tmr_exp)
  );

  hdx_rx_capture #(.DW(DW), .MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W), .AW(AW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .begin_i    (rx_begin),
    .byte_i     (rx_byte),
    .last_req_i (req_n_i),
    .data_i     (sr_rdata_i),
    .full_o     (rx_full),
    .wr_en_o    (rx_wr_en_o),
    .wr_addr_o  (rx_wr_addr_o),
    .wr_data_o  (rx_wr_data_o),
    .done_o     (frame_done_o),
    .type_o     (frame_type_o),
    .len_o      (frame_len_o),
    .ovf_o      (frame_ovf_o)
  );

  assign scnt_inc     = scnt_q + 1'b1;
  assign busy_o       = (st_q != ST_IDLE) || pend_q;
  assign accept       = tx_start_i && !busy_o;
  assign tx_rd_addr_o = (st_q == ST_TX) ? scnt_inc[AW-1:0] : '0;
  assign in_hs        = (st_q == ST_HS_A) || (st_q == ST_HS_B) ||
                        (st_q == ST_HS_C) || (st_q == ST_HS_D);

  always_comb begin
    st_d     = st_q;
    tip_d    = tip_q;
    ack_d    = ack_q;
    dir_d    = dir_q;
    load_d   = 1'b0;
    wdat_d   = wdat_q;
    pend_d   = pend_q;
    scnt_d   = scnt_q;
    len_d    = len_q;
    tmr_arm  = 1'b0;
    tmr_load = SHORT_LOAD;
    rx_begin = 1'b0;
    rx_byte  = 1'b0;
    start_tx = 1'b0;

    if (accept) begin
      pend_d = 1'b1;
      len_d  = tx_len_i;
    end

    unique case (st_q)
      ST_HS_A: if (tmr_exp) begin tip_d = 1'b0;   tmr_arm = 1'b1; st_d = ST_HS_B; end
      ST_HS_B: if (tmr_exp) begin ack_d = ~ack_q; tmr_arm = 1'b1; st_d = ST_HS_C; end
      ST_HS_C: if (tmr_exp) begin tip_d = 1'b1;   tmr_arm = 1'b1; st_d = ST_HS_D; end
      ST_HS_D: if (tmr_exp) begin ack_d = 1'b1;   tip_d = 1'b1;   st_d = ST_IDLE; end
      ST_IDLE: begin
        if (sr_done_i) begin
          if (req_n_i) begin
            if (pend_q) begin
              tmr_arm = 1'b1;
              st_d    = ST_HOLD;
            end
          end else begin
            tip_d    = 1'b0;
            dir_d    = 1'b0;
            rx_begin = 1'b1;
            st_d     = ST_RX;
          end
        end else if (pend_q && req_n_i) begin
          start_tx = 1'b1;
        end
      end
      ST_TX: begin
        if (sr_done_i) begin
          if (!req_n_i) begin
            dir_d    = 1'b0;
            ack_d    = 1'b1;
            tip_d    = 1'b0;
            scnt_d   = '0;
            rx_begin = 1'b1;
            st_d     = ST_RX;
          end else if (scnt_inc == len_q) begin
            pend_d = 1'b0;
            dir_d  = 1'b0;
            tip_d  = 1'b1;
            ack_d  = 1'b1;
            scnt_d = '0;
            st_d   = ST_IDLE;
          end else begin
            scnt_d = scnt_inc;
            load_d = 1'b1;
            wdat_d = tx_rd_data_i;
            ack_d  = ~ack_q;
          end
        end
      end
      ST_RX: begin
        if (sr_done_i) begin
          rx_byte = 1'b1;
          if (req_n_i || rx_full) begin
            tip_d = 1'b1;
            ack_d = 1'b1;
            if (pend_q) begin
              tmr_arm  = 1'b1;
              tmr_load = LONG_LOAD;
              st_d     = ST_HOLD;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            ack_d = ~ack_q;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          if (req_n_i) start_tx = 1'b1;
          else         st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (start_tx) begin
      st_d   = ST_TX;
      dir_d  = 1'b1;
      load_d = 1'b1;
      wdat_d = tx_rd_data_i;
      ack_d  = 1'b1;
      tip_d  = 1'b0;
      scnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HS_A;
      tip_q  <= 1'b1;
      ack_q  <= 1'b1;
      dir_q  <= 1'b0;
      load_q <= 1'b0;
      wdat_q <= '0;
      pend_q <= 1'b0;
      scnt_q <= '0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      tip_q  <= tip_d;
      ack_q  <= ack_d;
      dir_q  <= dir_d;
      load_q <= load_d;
      wdat_q <= wdat_d;
      pend_q <= pend_d;
      scnt_q <= scnt_d;
      len_q  <= len_d;
    end
  end

  assign tip_n_o      = tip_q;
  assign ack_o        = ack_q;
  assign sr_dir_out_o = dir_q;
  assign sr_load_o    = load_q;
  assign sr_wdata_o   = wdat_q;

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (tip_n_o && ack_o && !sr_dir_out_o));  // R1
  AST_HS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_hs |-> (!sr_load_o && !sr_dir_out_o && busy_o));  // R2
  AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_dir_out_o) |-> (!tip_n_o && ack_o && sr_load_o));  // R3
  AST_LOAD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load_o |-> sr_dir_out_o);  // R4
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX && sr_done_i && !req_n_i) |=>
      (st_q == ST_RX && !tip_n_o && ack_o && !sr_dir_out_o && pend_q));  // R5
  AST_RX_DIR_IN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en_o |-> !sr_dir_out_o);  // R8

endmodule

// File: tb/hdx_link_ctrl_bench.sv
module hdx_link_ctrl_bench;

  localparam int CPU     = 2;
  localparam int SHORT   = 150 * CPU;
  localparam int LONG    = 1500 * CPU;
  localparam int M_HS = 0, M_IDLE = 1, M_TX = 2, M_RX = 3, M_HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_start = 1'b0;
  logic [8:0] tx_len = 9'd0;
  logic [7:0] tx_rd_addr, tx_rd_data;
  logic       req_n = 1'b1;
  logic       tip_n, ack, dir_out, sr_load;
  logic [7:0] sr_wdata;
  logic [7:0] sr_rdata = 8'h00;
  logic       sr_done = 1'b0;
  logic       rx_we;
  logic [7:0] rx_addr, rx_data;
  logic       fdone;
  logic [7:0] ftype;
  logic [8:0] flen;
  logic       fovf, busy;

  logic [7:0] txmem [256];
  assign tx_rd_data = txmem[tx_rd_addr];

  always #5 clk = ~clk;

  hdx_link_ctrl #(.CYC_PER_US(CPU)) u_hdx_link_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_start_i(tx_start), .tx_len_i(tx_len),
    .tx_rd_addr_o(tx_rd_addr), .tx_rd_data_i(tx_rd_data), .req_n_i(req_n),
    .tip_n_o(tip_n), .ack_o(ack), .sr_dir_out_o(dir_out), .sr_load_o(sr_load),
    .sr_wdata_o(sr_wdata), .sr_rdata_i(sr_rdata), .sr_done_i(sr_done),
    .rx_wr_en_o(rx_we), .rx_wr_addr_o(rx_addr), .rx_wr_data_o(rx_data),
    .frame_done_o(fdone), .frame_type_o(ftype), .frame_len_o(flen),
    .frame_ovf_o(fovf), .busy_o(busy)
  );

  // Behavioural reference model, advanced on every rising edge.
  int  mode, hs_step, wait_left, sent, mlen, rcnt;
  bit  pend, m_tip, m_ack, m_dir, m_load, m_we, m_fd, m_ovf, acc, ovf_now;
  int  m_wdata, m_waddr, m_wd, m_type, m_len, first;

  task automatic m_start();
    mode = M_TX; m_dir = 1; m_load = 1; m_wdata = txmem[0];
    m_ack = 1; m_tip = 0; sent = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = M_HS; hs_step = 0; wait_left = SHORT; pend = 0;
      m_tip = 1; m_ack = 1; m_dir = 0; m_load = 0; m_we = 0; m_fd = 0;
      m_wdata = 0; m_waddr = 0; m_wd = 0; m_type = 0; m_len = 0; m_ovf = 0;
      sent = 0; mlen = 0; rcnt = 0; first = 0;
    end else begin
      m_load = 0; m_we = 0; m_fd = 0;
      acc = tx_start && !(mode != M_IDLE || pend);
      if (wait_left > 0) wait_left--;
      case (mode)
        M_HS: if (wait_left == 0) begin
          hs_step++;
          if (hs_step == 1) m_tip = 0;
          else if (hs_step == 2) m_ack = !m_ack;
          else if (hs_step == 3) m_tip = 1;
          else begin m_ack = 1; mode = M_IDLE; end
          if (hs_step < 4) wait_left = SHORT;
        end
        M_IDLE: begin
          if (sr_done) begin
            if (req_n) begin
              if (pend) begin wait_left = SHORT; mode = M_HOLD; end
            end else begin
              m_tip = 0; m_dir = 0; rcnt = 1; mode = M_RX;
            end
          end else if (pend && req_n) m_start();
        end
        M_TX: if (sr_done) begin
          sent++;
          if (!req_n) begin
            m_dir = 0; m_ack = 1; m_tip = 0; rcnt = 1; mode = M_RX;
          end else if (sent == mlen) begin
            pend = 0; m_dir = 0; m_tip = 1; m_ack = 1; mode = M_IDLE;
          end else begin
            m_load = 1; m_wdata = txmem[sent]; m_ack = !m_ack;
          end
        end
        M_RX: if (sr_done) begin
          m_we = 1; m_waddr = rcnt - 1; m_wd = sr_rdata;
          if (rcnt == 1) first = sr_rdata;
          ovf_now = (rcnt == 256);
          if (!ovf_now) rcnt++;
          if (req_n || ovf_now) begin
            m_fd = 1; m_type = first; m_len = rcnt - 2; m_ovf = ovf_now;
            m_tip = 1; m_ack = 1;
            if (pend) begin wait_left = LONG; mode = M_HOLD; end
            else mode = M_IDLE;
          end else m_ack = !m_ack;
        end
        M_HOLD: if (wait_left == 0) begin
          if (req_n) m_start(); else mode = M_IDLE;
        end
        default: mode = M_IDLE;
      endcase
      if (acc) begin pend = 1; mlen = int'(tx_len); end
    end
  end

  int    vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit    running = 1;

  task automatic cmp(string sig, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      vectors++;
      cmp("tip_n", int'(tip_n), int'(m_tip));
      cmp("ack", int'(ack), int'(m_ack));
      cmp("dir", int'(dir_out), int'(m_dir));
      cmp("load", int'(sr_load), int'(m_load));
      if (m_load) cmp("wdata", int'(sr_wdata), m_wdata);
      cmp("rx_we", int'(rx_we), int'(m_we));
      if (m_we) begin
        cmp("rx_addr", int'(rx_addr), m_waddr);
        cmp("rx_data", int'(rx_data), m_wd);
      end
      cmp("frame_done", int'(fdone), int'(m_fd));
      if (m_fd) begin
        cmp("frame_type", int'(ftype), m_type);
        cmp("frame_len", int'(flen), m_len);
        cmp("frame_ovf", int'(fovf), int'(m_ovf));
      end
      cmp("busy", int'(busy), int'(mode != M_IDLE || pend));
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL %s watchdog: actual %0d expected below 150000 cycles", cur_req, cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic byte_evt(logic [7:0] b, logic rq);
    @(negedge clk); req_n = rq; sr_rdata = b; sr_done = 1'b1;
    @(negedge clk); sr_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_pulse(int n);
    @(negedge clk); tx_start = 1'b1; tx_len = 9'(n);
    @(negedge clk); tx_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) txmem[i] = 8'(8'h40 + i * 3);
    cur_req = "R2";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    byte_evt(8'h5A, 1'b0);          // ignored during handshake (R2)
    start_pulse(2);                 // ignored: busy during handshake (R12)
    repeat (4 * SHORT) @(negedge clk);

    cur_req = "R1";
    repeat (10) @(negedge clk);

    cur_req = "R3 R4 R12";
    start_pulse(3);
    start_pulse(5);                 // busy: ignored (R12)
    byte_evt(8'h00, 1'b1);
    byte_evt(8'h00, 1'b1);
    byte_evt(8'h00, 1'b1);
    repeat (5) @(negedge clk);

    cur_req = "R6";
    byte_evt(8'h77, 1'b1);          // spurious, nothing pending
    @(negedge clk); req_n = 1'b0;
    start_pulse(2);                 // pending, held off by request
    byte_evt(8'h78, 1'b1);          // spurious with pending: restart after S
    repeat (SHORT + 5) @(negedge clk);
    byte_evt(8'h00, 1'b1);
    byte_evt(8'h00, 1'b1);

    cur_req = "R7 R8 R9";
    @(negedge clk); req_n = 1'b0;
    byte_evt(8'hE0, 1'b0);          // attention byte
    byte_evt(8'h11, 1'b0);
    byte_evt(8'hA1, 1'b0);
    byte_evt(8'hA2, 1'b0);
    byte_evt(8'hA3, 1'b1);          // last byte
    repeat (5) @(negedge clk);

    cur_req = "R5 R11";
    start_pulse(4);
    byte_evt(8'h00, 1'b1);
    byte_evt(8'hE1, 1'b0);          // collision
    byte_evt(8'h22, 1'b0);
    byte_evt(8'hB1, 1'b0);
    byte_evt(8'hB2, 1'b1);
    repeat (LONG + 5) @(negedge clk);
    for (int i = 0; i < 4; i++) byte_evt(8'h00, 1'b1);

    cur_req = "R11";
    @(negedge clk); req_n = 1'b0;
    start_pulse(2);
    byte_evt(8'hE2, 1'b0);
    byte_evt(8'h33, 1'b0);
    byte_evt(8'hC1, 1'b1);
    @(negedge clk); req_n = 1'b0;   // still requesting when wait ends
    repeat (LONG + 5) @(negedge clk);
    req_n = 1'b1;
    repeat (5) @(negedge clk);
    byte_evt(8'h00, 1'b1);
    byte_evt(8'h00, 1'b1);

    cur_req = "R10";
    @(negedge clk); req_n = 1'b0;
    byte_evt(8'hE3, 1'b0);
    for (int i = 0; i < 256; i++) byte_evt(8'(i + 7), 1'b0);
    @(negedge clk); req_n = 1'b1;
    repeat (10) @(negedge clk);

    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule